// File: doc/BRIEF.md
# Least-Frequently-Used Way Replacement Engine

This block picks replacement victims for a set-associative tag store using a least-frequently-used rule. It holds a valid flag and a saturating use counter for every way of every set, plus one inherited count per set. The surrounding cache controller sends one command per cycle. A command is a query, a hit, a fill or an evict, and it names a set and, where it matters, a way. The block answers queries with a way number. It never compares tags or moves data.

A way that is evicted does not lose its history entirely. Its count moves into the set's inherited count, and the next fill in that set starts from that inherited count plus one. A newly loaded line therefore starts near the usage level of what it replaced. This keeps fresh lines from being pushed out at once by long-resident ones. A query prefers any empty way over count comparison. Among full sets it takes the smallest count, and the lowest way number wins a tie.

Top module: `lfu_repl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `victim_valid` is 0. After reset every way of every set is invalid and every way count and set count is 0, so the first query of any set returns way 0.
- R2: A query (`cmd_valid`=1, `cmd_op`=2'b00) raises `victim_valid` for exactly the following cycle, with the answer on `victim_way`. In any cycle that follows a non-query cycle, `victim_valid` is 0.
- R3: If the queried set holds at least one invalid way, the answer is the lowest-numbered invalid way, whatever the counts are.
- R4: If every way of the queried set is valid, the answer is the way with the smallest count. Among equal counts the lowest-numbered way is chosen.
- R5: A hit (`cmd_op`=2'b01) on a valid way raises that way's count by one. The count stays at its maximum (2^CNT_W-1) instead of wrapping.
- R6: A hit on an invalid way changes nothing: the way stays invalid and its count is unchanged.
- R7: An evict (`cmd_op`=2'b11) copies the named way's count into its set's inherited count, clears the way's count to 0 and marks the way invalid.
- R8: A fill (`cmd_op`=2'b10) marks the named way valid and sets its count to the set's inherited count plus one, saturating at the maximum.
- R9: A command changes only the set it names. Queries of other sets are unaffected.
- R10: A query answers from the state before the query's own clock edge. Updates take effect at the clock edge of their command, so a query in the next cycle sees them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 query, 01 hit, 10 fill, 11 evict |
| cmd_set | input | $clog2(SETS) | Set addressed by the command |
| cmd_way | input | $clog2(WAYS) | Way addressed by hit, fill or evict |
| victim_valid | output | 1 | Answer strobe, one cycle after a query |
| victim_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
The answer to a query appears at the first clock edge after the query. The bench drives commands on the falling edge and reads `victim_valid` and `victim_way` on the next falling edge, half a cycle after the registered result settles. Hit, fill and evict updates are not visible at the ports. They land at their own edge and show up only through the answer to a query issued on a later cycle. The directed sequences therefore follow each update with a query whose result depends on it. A behavioural model, stepped at every rising edge, predicts the strobe and the way. Its predictions are compared on every falling edge, through the directed sequences and a random stream alike.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

    // Command encoding on cmd_op
    typedef enum logic [1:0] {
        OP_QUERY = 2'b00,
        OP_HIT   = 2'b01,
        OP_FILL  = 2'b10,
        OP_EVICT = 2'b11
    } lfu_op_e;

    // Default geometry
    localparam int LFU_SETS  = 8;
    localparam int LFU_WAYS  = 4;
    localparam int LFU_CNT_W = 4;

    // Registered answer to a query
    typedef struct packed {
        logic       strobe;
        logic [7:0] way;
    } lfu_answer_t;

endpackage

// File: rtl/lfu_cnt_store.sv
module lfu_cnt_store
    import lfu_pkg::*;
#(
    parameter int SETS  = LFU_SETS,
    parameter int WAYS  = LFU_WAYS,
    parameter int CNT_W = LFU_CNT_W,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd_en,
    input  lfu_op_e                     upd_op,
    input  logic [SET_W-1:0]            upd_set,
    input  logic [WAY_W-1:0]            upd_way,
    output logic [SETS*WAYS-1:0]        valid_flat,
    output logic [SETS*WAYS*CNT_W-1:0]  cnt_flat,
    output logic [SETS*CNT_W-1:0]       setcnt_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [CNT_W-1:0] row_cnt [WAYS];
        logic [CNT_W-1:0] base_q;
        logic [CNT_W-1:0] fill_cnt;
        logic             set_sel;

        assign set_sel  = upd_en && (upd_set == SET_W'(s));
        assign fill_cnt = (base_q == CNT_MAX) ? CNT_MAX : base_q + 1'b1;

        // inherited count: takes the evicted way's count
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
            end else if (set_sel && upd_op == OP_EVICT) begin
                base_q <= row_cnt[upd_way];
            end
        end

        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic             v_q;
            logic [CNT_W-1:0] c_q;
            logic             way_sel;

            assign way_sel = set_sel && (upd_way == WAY_W'(w));

            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    c_q <= '0;
                end else if (way_sel) begin
                    case (upd_op)
                        OP_HIT: begin
                            if (v_q && c_q != CNT_MAX) c_q <= c_q + 1'b1;
                        end
                        OP_FILL: begin
                            v_q <= 1'b1;
                            c_q <= fill_cnt;
                        end
                        OP_EVICT: begin
                            v_q <= 1'b0;
                            c_q <= '0;
                        end
                        default: ;
                    endcase
                end
            end

            assign row_cnt[w]                              = c_q;
            assign valid_flat[s*WAYS+w]                    = v_q;
            assign cnt_flat[(s*WAYS+w)*CNT_W +: CNT_W]     = c_q;
        end

        assign setcnt_flat[s*CNT_W +: CNT_W] = base_q;
    end

endmodule

// File: rtl/lfu_victim_pick.sv
module lfu_victim_pick
    import lfu_pkg::*;
#(
    parameter int WAYS  = LFU_WAYS,
    parameter int CNT_W = LFU_CNT_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]        row_valid,
    input  logic [WAYS*CNT_W-1:0]  row_cnt,
    output logic [WAY_W-1:0]       pick_way
);

    logic             have_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] min_way;
    logic [CNT_W-1:0] min_cnt;

    // lowest-numbered empty way
    always_comb begin
        have_free = 1'b0;
        free_way  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!have_free && !row_valid[w]) begin
                have_free = 1'b1;
                free_way  = WAY_W'(w);
            end
        end
    end

    // smallest count, strict compare keeps the lower way on ties
    always_comb begin
        min_way = '0;
        min_cnt = row_cnt[0 +: CNT_W];
        for (int w = 1; w < WAYS; w++) begin
            if (row_cnt[w*CNT_W +: CNT_W] < min_cnt) begin
                min_cnt = row_cnt[w*CNT_W +: CNT_W];
                min_way = WAY_W'(w);
            end
        end
    end

    assign pick_way = have_free ? free_way : min_way;

endmodule

// File: rtl/lfu_repl.sv
module lfu_repl
    import lfu_pkg::*;
#(
    parameter int SETS  = LFU_SETS,
    parameter int WAYS  = LFU_WAYS,
    parameter int CNT_W = LFU_CNT_W,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [SET_W-1:0] cmd_set,
    input  logic [WAY_W-1:0] cmd_way,
    output logic             victim_valid,
    output logic [WAY_W-1:0] victim_way
);

    lfu_op_e                    op;
    logic                       is_query;
    logic [SETS*WAYS-1:0]       valid_flat;
    logic [SETS*WAYS*CNT_W-1:0] cnt_flat;
    logic [SETS*CNT_W-1:0]      setcnt_flat;
    logic [WAYS-1:0]            row_valid;
    logic [WAYS*CNT_W-1:0]      row_cnt;
    logic [WAY_W-1:0]           pick_way;

    assign op       = lfu_op_e'(cmd_op);
    assign is_query = cmd_valid && (op == OP_QUERY);

    lfu_cnt_store #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .upd_en     (cmd_valid),
        .upd_op     (op),
        .upd_set    (cmd_set),
        .upd_way    (cmd_way),
        .valid_flat (valid_flat),
        .cnt_flat   (cnt_flat),
        .setcnt_flat(setcnt_flat)
    );

    // row of the addressed set
    always_comb begin
        row_valid = valid_flat[int'(cmd_set)*WAYS +: WAYS];
        row_cnt   = cnt_flat[int'(cmd_set)*WAYS*CNT_W +: WAYS*CNT_W];
    end

    lfu_victim_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) u_pick (
        .row_valid(row_valid),
        .row_cnt  (row_cnt),
        .pick_way (pick_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid <= 1'b0;
            victim_way   <= '0;
        end else begin
            victim_valid <= is_query;
            if (is_query) victim_way <= pick_way;
        end
    end

endmodule

// File: rtl/lfu_repl_chk.sv
module lfu_repl_chk
    import lfu_pkg::*;
#(
    parameter int SETS  = LFU_SETS,
    parameter int WAYS  = LFU_WAYS,
    parameter int CNT_W = LFU_CNT_W,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cmd_valid,
    input logic [1:0]                 cmd_op,
    input logic [SET_W-1:0]           cmd_set,
    input logic [WAY_W-1:0]           cmd_way,
    input logic                       victim_valid,
    input logic [WAY_W-1:0]           victim_way,
    input logic [SETS*WAYS-1:0]       valid_flat,
    input logic [SETS*WAYS*CNT_W-1:0] cnt_flat,
    input logic [SETS*CNT_W-1:0]      setcnt_flat
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic                  p_v;
    logic [1:0]            p_op;
    logic [SET_W-1:0]      p_set;
    logic [WAY_W-1:0]      p_way;
    logic [CNT_W-1:0]      p_cnt, p_setcnt;
    logic                  p_valid;
    logic [WAYS-1:0]       p_row_v;
    logic [WAYS*CNT_W-1:0] p_row_c;
    logic [CNT_W-1:0]      now_cnt, now_setcnt;
    logic                  now_valid;
    logic                  lower_full, is_min;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_v <= 1'b0; p_op <= '0; p_set <= '0; p_way <= '0;
            p_cnt <= '0; p_setcnt <= '0; p_valid <= 1'b0;
            p_row_v <= '0; p_row_c <= '0;
        end else begin
            p_v      <= cmd_valid;
            p_op     <= cmd_op;
            p_set    <= cmd_set;
            p_way    <= cmd_way;
            p_cnt    <= cnt_flat[(int'(cmd_set)*WAYS+int'(cmd_way))*CNT_W +: CNT_W];
            p_setcnt <= setcnt_flat[int'(cmd_set)*CNT_W +: CNT_W];
            p_valid  <= valid_flat[int'(cmd_set)*WAYS+int'(cmd_way)];
            p_row_v  <= valid_flat[int'(cmd_set)*WAYS +: WAYS];
            p_row_c  <= cnt_flat[int'(cmd_set)*WAYS*CNT_W +: WAYS*CNT_W];
        end
    end

    always_comb begin
        now_cnt    = cnt_flat[(int'(p_set)*WAYS+int'(p_way))*CNT_W +: CNT_W];
        now_setcnt = setcnt_flat[int'(p_set)*CNT_W +: CNT_W];
        now_valid  = valid_flat[int'(p_set)*WAYS+int'(p_way)];
        lower_full = 1'b1;
        is_min     = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (w < int'(victim_way) && !p_row_v[w]) lower_full = 1'b0;
            if (w < int'(victim_way) &&
                p_row_c[w*CNT_W +: CNT_W] <= p_row_c[int'(victim_way)*CNT_W +: CNT_W])
                is_min = 1'b0;
            if (w > int'(victim_way) &&
                p_row_c[w*CNT_W +: CNT_W] < p_row_c[int'(victim_way)*CNT_W +: CNT_W])
                is_min = 1'b0;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!victim_valid && valid_flat == '0 && cnt_flat == '0 && setcnt_flat == '0));

    p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b00) |=> victim_valid);

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 2'b00) |=> !victim_valid);

    p_free_first_r3: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && !(&p_row_v)) |-> (!p_row_v[victim_way] && lower_full));

    p_min_count_r4: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && (&p_row_v)) |-> is_min);

    p_hit_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (p_v && p_op == 2'b01 && p_valid) |->
        (now_cnt == ((p_cnt == CNT_MAX) ? CNT_MAX : p_cnt + 1'b1)));

    p_hit_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (p_v && p_op == 2'b01 && !p_valid) |-> (now_cnt == p_cnt && !now_valid));

    p_evict_r7: assert property (@(posedge clk) disable iff (rst)
        (p_v && p_op == 2'b11) |-> (now_setcnt == p_cnt && now_cnt == '0 && !now_valid));

    p_fill_r8: assert property (@(posedge clk) disable iff (rst)
        (p_v && p_op == 2'b10) |->
        (now_valid && now_cnt == ((p_setcnt == CNT_MAX) ? CNT_MAX : p_setcnt + 1'b1)));

endmodule

bind lfu_repl lfu_repl_chk #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_set     (cmd_set),
    .cmd_way     (cmd_way),
    .victim_valid(victim_valid),
    .victim_way  (victim_way),
    .valid_flat  (valid_flat),
    .cnt_flat    (cnt_flat),
    .setcnt_flat (setcnt_flat)
);

// File: tb/sim_lfu_repl.sv
`timescale 1ns/1ps
module sim_lfu_repl;

    localparam int SETS = 8;
    localparam int WAYS = 4;
    localparam int CNT_W = 4;
    localparam int MAXC = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [2:0] cmd_set = '0;
    logic [1:0] cmd_way = '0;
    logic       victim_valid;
    logic [1:0] victim_way;

    int checks = 0;
    int fails  = 0;
    bit armed  = 1'b0;

    always #5 clk = ~clk;

    lfu_repl #(.SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_set(cmd_set), .cmd_way(cmd_way),
        .victim_valid(victim_valid), .victim_way(victim_way)
    );

    // behavioural reference model
    int    m_val [SETS][WAYS];
    int    m_cnt [SETS][WAYS];
    int    m_base[SETS];
    bit    m_vv;
    int    m_vw;
    string m_req;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_val[s, w]) begin m_val[s][w] = 0; m_cnt[s][w] = 0; end
            foreach (m_base[s]) m_base[s] = 0;
            m_vv = 0; m_vw = 0;
        end else begin
            int s, w;
            s = int'(cmd_set); w = int'(cmd_way);
            m_vv = cmd_valid && cmd_op == 2'b00;
            if (m_vv) begin
                int free, best;
                free = -1;
                for (int k = WAYS - 1; k >= 0; k--) if (m_val[s][k] == 0) free = k;
                best = 0;
                for (int k = 1; k < WAYS; k++) if (m_cnt[s][k] < m_cnt[s][best]) best = k;
                m_vw  = (free >= 0) ? free : best;
                m_req = (free >= 0) ? "R3" : "R4";
            end
            if (cmd_valid) begin
                case (cmd_op)
                    2'b01: if (m_val[s][w] != 0 && m_cnt[s][w] < MAXC) m_cnt[s][w]++;
                    2'b10: begin
                        m_val[s][w] = 1;
                        m_cnt[s][w] = (m_base[s] < MAXC) ? m_base[s] + 1 : MAXC;
                    end
                    2'b11: begin
                        m_base[s] = m_cnt[s][w];
                        m_cnt[s][w] = 0;
                        m_val[s][w] = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !rst) begin
            chk(victim_valid == m_vv, "R2", int'(victim_valid), int'(m_vv));
            if (m_vv) chk(int'(victim_way) == m_vw, m_req, int'(victim_way), m_vw);
        end
    end

    task automatic cmd(input logic [1:0] op, input int s, input int w);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_set   = 3'(s);
        cmd_way   = 2'(w);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ask(input int s, input int exp, input string req);
        cmd(2'b00, s, 0);
        chk(victim_valid && int'(victim_way) == exp, req, int'(victim_way), exp);
    endtask

    task automatic hits(input int s, input int w, input int n);
        for (int i = 0; i < n; i++) cmd(2'b01, s, w);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        armed = 1'b1;
        repeat (3) @(negedge clk);
        chk(victim_valid == 1'b0, "R1", int'(victim_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(victim_valid == 1'b0, "R1", int'(victim_valid), 0);
        ask(1, 0, "R1");
        ask(5, 0, "R1");

        // R3: empty ways taken lowest first
        cmd(2'b10, 1, 0); ask(1, 1, "R3");
        cmd(2'b10, 1, 2); ask(1, 1, "R3");
        cmd(2'b10, 1, 1); ask(1, 3, "R3");
        cmd(2'b10, 1, 3);
        // R4: all counts 1, tie -> way 0
        ask(1, 0, "R4");
        // R5 / R4: counts become 3,2,2,1
        hits(1, 0, 2); hits(1, 1, 1); hits(1, 2, 1);
        ask(1, 3, "R4");
        hits(1, 3, 3);                   // 3,2,2,4
        ask(1, 1, "R4");
        // R7: evict way1 (count 2) -> invalid
        cmd(2'b11, 1, 1);
        ask(1, 1, "R7");
        // R6: hit on invalid way leaves it invalid
        cmd(2'b01, 1, 1);
        ask(1, 1, "R6");
        // R8: fill inherits 2 -> count 3; counts 3,3,2,4
        cmd(2'b10, 1, 1);
        ask(1, 2, "R8");

        // R5 saturation on set 3
        for (int w = 0; w < WAYS; w++) cmd(2'b10, 3, w);
        hits(3, 0, 20); hits(3, 1, 14); hits(3, 2, 14); hits(3, 3, 13);
        ask(3, 3, "R5");
        cmd(2'b01, 3, 3);
        ask(3, 0, "R5");
        // R8 saturation: inherited 15 -> fill stays 15
        cmd(2'b11, 3, 2);
        cmd(2'b10, 3, 2);
        ask(3, 0, "R8");

        // R9: other sets untouched
        ask(1, 2, "R9");
        ask(0, 0, "R9");
        // R10: query right after update sees it
        cmd(2'b11, 1, 3);
        ask(1, 3, "R10");

        // random stream, model compare each cycle
        for (int i = 0; i < 3000; i++) begin
            cmd_valid = ($urandom_range(0, 7) != 0);
            cmd_op    = 2'($urandom_range(0, 3));
            cmd_set   = 3'($urandom_range(0, 3));
            cmd_way   = 2'($urandom_range(0, 3));
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule